// File: doc/BRIEF.md
# Interrupt Status and Control Register

This block is the host-facing control and status word of a peripheral interface. The host writes a 16-bit control word that holds per-source interrupt enables, a global enable, a DMA enable and a soft-reset command. The host reads back a separate 16-bit status word. The status word does not echo the control word. It reports latched events, a few mirrored enables, constant identification bits, two configuration straps and two live button levels.

Three event sources feed the block: a pair of trigger inputs, a timer-limit pulse and a block-transfer-end pulse. All of them are asynchronous. Each input passes through a two-flop synchronizer and an edge detector. A rising edge sets a sticky flag, and any status read clears all sticky flags together. An event that arrives in the same cycle as the read is kept. The block computes an interrupt request from the flags, the per-source enables and the global enable, and routes it to the low or the high priority line according to the select code. When the host polls the matching priority group, the block answers on the data bit for its select code and drops its pending request.

Top module: `irq_status_ctrl`

## Requirements
- R1: A control write (`wr_ctrl_i`) stores `wdata_i`. The status word shows control bits 6 and 7 only, at status bits 6 and 7. No other control bit appears in the status word.
- R2: Status bits 3 to 5 carry the parameter `ID_CODE` (default 3'b101). Bit 8 is constant 1. Bits 9 and 10 follow `strap_i[0]` and `strap_i[1]`. Bit 15 is 0.
- R3: A rising edge on `timer_evt_i` sets status bit 1. A rising edge on `xfer_evt_i` sets status bit 2. A rising edge on `trig_i[0]` sets bits 0 and 11. A rising edge on `trig_i[1]` sets bits 0 and 12. A level held high sets its flag once only, and a flag is set whether or not its enable is set.
- R4: A status read strobe (`rd_stat_i`) clears status bits 0, 1, 2, 11 and 12. Bits 6, 7, 13 and 14 are not changed by the read.
- R5: If an event edge reaches the flags in the same cycle as a status read strobe, its flag is set after the clear, so the event is not lost.
- R6: Status bits 13 and 14 show the present levels of `btn_i[0]` and `btn_i[1]`.
- R7: An interrupt is requested only while (bit 0 & control bit 0) | (bit 1 & control bit 1) | (bit 2 & control bit 2) holds and control bit 7 is set. The request appears on `irq_lo_o` when `sel_i` is 0 to 7 and on `irq_hi_o` when `sel_i` is 8 to 15. The other line stays low.
- R8: A poll (`poll_i`) whose group (`poll_grp_i`: 0 selects low, 1 selects high) matches the group of the pending request drives `poll_resp_o` with only bit `sel_i[2:0]` set, in that same cycle. Otherwise `poll_resp_o` is 0. After a matching poll the request line is low. It is raised again only when the request condition goes false and then true again.
- R9: Writing control bit 5 as 1, or asserting `bus_init_i` for one cycle, clears the control word, all event flags and any pending request.
- R10: The enable bits stay set across interrupts, polls and status reads. A new event after a read raises a new request with no rewrite of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_init_i | input | 1 | Synchronous interface initialise |
| wr_ctrl_i | input | 1 | Control word write strobe |
| wdata_i | input | 16 | Control word write data |
| rd_stat_i | input | 1 | Status read strobe (clears event flags) |
| stat_o | output | 16 | Status word |
| trig_i | input | 2 | Asynchronous trigger inputs |
| timer_evt_i | input | 1 | Asynchronous timer-limit event |
| xfer_evt_i | input | 1 | Asynchronous block-transfer-end event |
| btn_i | input | 2 | Button levels |
| strap_i | input | 2 | Configuration straps |
| sel_i | input | 4 | Interface select code |
| poll_i | input | 1 | Interrupt poll strobe |
| poll_grp_i | input | 1 | Polled priority group (0 low, 1 high) |
| irq_lo_o | output | 1 | Low priority interrupt request |
| irq_hi_o | output | 1 | High priority interrupt request |
| poll_resp_o | output | 8 | Poll answer, one bit per select code in the group |

## Verification
Two things can fall in the same cycle: a status read that clears the flags, and a synchronized event edge that sets one. The bench raises an event input, counts the two synchronizer stages and the edge register, and places the read strobe in exactly the cycle in which the edge reaches the flags. It then expects the flag set and the request raised. The same kind of collision is used for a poll against a standing request and for a soft reset against event activity. Randomized control words, straps, buttons, select codes and overlapping event pulses are checked against a bench model of the status word and the request lines.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;
  localparam int unsigned WORD_W = 16;

  // status/control bit positions
  localparam int unsigned B_TRIG   = 0;
  localparam int unsigned B_TIMER  = 1;
  localparam int unsigned B_XFER   = 2;
  localparam int unsigned B_ID_LO  = 3;
  localparam int unsigned B_RST    = 5;
  localparam int unsigned B_DMA    = 6;
  localparam int unsigned B_GIE    = 7;
  localparam int unsigned B_INST   = 8;
  localparam int unsigned B_STRAP  = 9;
  localparam int unsigned B_TRIG0  = 11;
  localparam int unsigned B_BTN    = 13;

  // flag vector layout
  localparam int unsigned F_TRIG  = 0;
  localparam int unsigned F_TIMER = 1;
  localparam int unsigned F_XFER  = 2;
  localparam int unsigned F_T0    = 3;
  localparam int unsigned N_FLAGS = 5;
endpackage

// File: rtl/irqsc_sync.sv
module irqsc_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        prev_q  <= chain_q[LAST];
      end
    end
    assign rise_o[g] = chain_q[LAST] & ~prev_q;

    p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/irqsc_flags.sv
module irqsc_flags #(
  parameter int unsigned NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_all_i,
  input  logic          rd_clr_i,
  input  logic [NF-1:0] set_i,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] flags_q;

  // set after clear: a same-cycle edge survives a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= '0;
    else if (clr_all_i) flags_q <= '0;
    else                flags_q <= (rd_clr_i ? '0 : flags_q) | set_i;
  end
  assign flags_o = flags_q;

  p_edge_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i && !clr_all_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && set_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/irqsc_req.sv
module irqsc_req #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             cond_i,
  input  logic             poll_i,
  input  logic             poll_grp_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             irq_lo_o,
  output logic             irq_hi_o,
  output logic [(1<<(SEL_W-1))-1:0] resp_o
);
  localparam int unsigned GRP_N = 1 << (SEL_W - 1);

  logic pend_q, cond_q, active, hit;

  assign active = pend_q & cond_i;
  assign hit    = poll_i & active & (poll_grp_i == sel_i[SEL_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cond_q <= 1'b0;
    end else if (clr_all_i) begin
      pend_q <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      if (!cond_i || hit)       pend_q <= 1'b0;
      else if (cond_i && !cond_q) pend_q <= 1'b1;
    end
  end

  assign irq_lo_o = active & ~sel_i[SEL_W-1];
  assign irq_hi_o = active &  sel_i[SEL_W-1];

  always_comb begin
    resp_o = '0;
    if (hit) resp_o[sel_i[SEL_W-2:0]] = 1'b1;
  end

  p_lines_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_lo_o && irq_hi_o));
  p_irq_needs_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o || irq_hi_o) |-> cond_i);
  p_poll_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> !(irq_lo_o || irq_hi_o));
  p_resp_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(resp_o) && (GRP_N > 0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqsc_pkg::*;
#(
  parameter logic [2:0]  ID_CODE     = 3'b101,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_init_i,
  input  logic        wr_ctrl_i,
  input  logic [15:0] wdata_i,
  input  logic        rd_stat_i,
  output logic [15:0] stat_o,
  input  logic [1:0]  trig_i,
  input  logic        timer_evt_i,
  input  logic        xfer_evt_i,
  input  logic [1:0]  btn_i,
  input  logic [1:0]  strap_i,
  input  logic [3:0]  sel_i,
  input  logic        poll_i,
  input  logic        poll_grp_i,
  output logic        irq_lo_o,
  output logic        irq_hi_o,
  output logic [7:0]  poll_resp_o
);
  localparam int unsigned N_EVT = 4;

  logic [WORD_W-1:0]  ctrl_q;
  logic               soft_rst;
  logic [N_EVT-1:0]   rise;
  logic [N_FLAGS-1:0] set_v, flags;
  logic               cond;

  assign soft_rst = bus_init_i | (wr_ctrl_i & wdata_i[B_RST]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (soft_rst)  ctrl_q <= '0;
    else if (wr_ctrl_i) ctrl_q <= wdata_i;
  end

  irqsc_sync #(.N(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({xfer_evt_i, timer_evt_i, trig_i}),
    .rise_o(rise)
  );

  always_comb begin
    set_v            = '0;
    set_v[F_TRIG]    = rise[0] | rise[1];
    set_v[F_TIMER]   = rise[2];
    set_v[F_XFER]    = rise[3];
    set_v[F_T0]      = rise[0];
    set_v[F_T0+1]    = rise[1];
  end

  irqsc_flags #(.NF(N_FLAGS)) u_flags (
    .clk_i, .rst_ni,
    .clr_all_i(soft_rst),
    .rd_clr_i (rd_stat_i),
    .set_i    (set_v),
    .flags_o  (flags)
  );

  assign cond = |(flags[F_XFER:F_TRIG] & ctrl_q[B_XFER:B_TRIG]) & ctrl_q[B_GIE];

  irqsc_req #(.SEL_W(4)) u_req (
    .clk_i, .rst_ni,
    .clr_all_i (soft_rst),
    .cond_i    (cond),
    .poll_i,
    .poll_grp_i,
    .sel_i,
    .irq_lo_o,
    .irq_hi_o,
    .resp_o    (poll_resp_o)
  );

  always_comb begin
    stat_o                      = '0;
    stat_o[B_XFER:B_TRIG]       = flags[F_XFER:F_TRIG];
    stat_o[B_ID_LO+2:B_ID_LO]   = ID_CODE;
    stat_o[B_DMA]               = ctrl_q[B_DMA];
    stat_o[B_GIE]               = ctrl_q[B_GIE];
    stat_o[B_INST]              = 1'b1;
    stat_o[B_STRAP+1:B_STRAP]   = strap_i;
    stat_o[B_TRIG0+1:B_TRIG0]   = flags[F_T0+1:F_T0];
    stat_o[B_BTN+1:B_BTN]       = btn_i;
  end

  p_soft_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (flags == '0 && !stat_o[B_GIE] && !stat_o[B_DMA]
                  && !irq_lo_o && !irq_hi_o));
  p_no_irq_wo_gie_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o || irq_hi_o) |-> stat_o[B_GIE]);
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_init = 0, wr_ctrl = 0, rd_stat = 0, poll = 0, poll_grp = 0;
  logic [15:0] wdata = '0, stat;
  logic [1:0]  trig = '0, btn = '0, strap = '0;
  logic        timer_evt = 0, xfer_evt = 0, irq_lo, irq_hi;
  logic [3:0]  sel = '0;
  logic [7:0]  resp;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [4:0]  m_f = '0;   // model flags: trig, timer, xfer, t0, t1
  logic [15:0] m_c = '0;   // model control word

  always #2.5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk_i(clk), .rst_ni, .bus_init_i(bus_init), .wr_ctrl_i(wr_ctrl),
    .wdata_i(wdata), .rd_stat_i(rd_stat), .stat_o(stat), .trig_i(trig),
    .timer_evt_i(timer_evt), .xfer_evt_i(xfer_evt), .btn_i(btn),
    .strap_i(strap), .sel_i(sel), .poll_i(poll), .poll_grp_i(poll_grp),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .poll_resp_o(resp)
  );

  function automatic logic [15:0] exp_stat(logic [4:0] f, logic [15:0] c,
                                           logic [1:0] b, logic [1:0] s);
    logic [15:0] r = '0;
    r[0] = f[0]; r[1] = f[1]; r[2] = f[2];
    r[5:3] = 3'b101;
    r[6] = c[6]; r[7] = c[7]; r[8] = 1'b1;
    r[10:9] = s; r[12:11] = f[4:3]; r[14:13] = b;
    return r;
  endfunction

  function automatic logic [1:0] exp_irq(logic [4:0] f, logic [15:0] c, logic [3:0] sl);
    logic cnd = (|(f[2:0] & c[2:0])) & c[7];
    return {cnd & sl[3], cnd & ~sl[3]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(logic [15:0] v);
    wdata = v; wr_ctrl = 1; tick(); wr_ctrl = 0;
    m_c = v[5] ? 16'h0 : v;
    if (v[5]) m_f = '0;
  endtask

  task automatic read_stat();
    rd_stat = 1; tick(); rd_stat = 0; m_f = '0;
  endtask

  // m: bit0 trig0, bit1 trig1, bit2 timer, bit3 xfer
  task automatic pulse(logic [3:0] m);
    trig = m[1:0]; timer_evt = m[2]; xfer_evt = m[3];
    tick(4);
    trig = '0; timer_evt = 0; xfer_evt = 0;
    tick(4);
    m_f[0] |= m[0] | m[1]; m_f[1] |= m[2]; m_f[2] |= m[3];
    m_f[3] |= m[0]; m_f[4] |= m[1];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(2);
    chk("R2 reset status", stat, exp_stat('0, '0, '0, '0));
    chk("R7 reset irq", {14'd0, irq_hi, irq_lo}, 16'd0);
    rst_ni = 1; tick(2);

    // R2 straps, R6 buttons
    strap = 2'b10; btn = 2'b01; tick();
    chk("R2/R6 straps buttons", stat, exp_stat(m_f, m_c, btn, strap));

    // R1 only bits 6,7 mirrored
    write_ctrl(16'hFFDF); tick();
    chk("R1 ctrl not echoed", stat, exp_stat(m_f, m_c, btn, strap));
    write_ctrl(16'h0000);

    // R3 timer edge with enables clear, held high sets once
    timer_evt = 1; tick(5);
    chk("R3 timer flag", stat, exp_stat(5'b00010, m_c, btn, strap));
    chk("R7 no irq without enables", {14'd0, irq_hi, irq_lo}, 16'd0);
    read_stat(); tick(4);
    chk("R3 held level sets once", stat, exp_stat('0, m_c, btn, strap));
    timer_evt = 0; tick(4);

    // R3 trig1 sets 0 and 12; R4 read clears but keeps buttons
    btn = 2'b11;
    pulse(4'b0010);
    chk("R3 trig1 flags", stat, exp_stat(5'b10001, m_c, btn, strap));
    read_stat();
    chk("R4 read clears", stat, exp_stat('0, m_c, btn, strap));

    // R7 low line
    sel = 4'd3; write_ctrl(16'h0082);
    pulse(4'b0100);
    chk("R7 irq low line", {14'd0, irq_hi, irq_lo}, 16'd1);
    // R8 mismatched poll
    poll = 1; poll_grp = 1; #1;
    chk("R8 mismatch poll", {8'd0, resp}, 16'd0);
    tick(); poll_grp = 0; #1;
    chk("R8 matching poll resp", {8'd0, resp}, 16'h0008);
    tick(); poll = 0;
    chk("R8 poll drops irq", {14'd0, irq_hi, irq_lo}, 16'd0);
    chk("R10 enables kept", stat, exp_stat(m_f, m_c, btn, strap));
    read_stat();
    pulse(4'b0100);
    chk("R10 new event re-raises", {14'd0, irq_hi, irq_lo}, 16'd1);
    read_stat(); tick();
    chk("R4 read drops irq", {14'd0, irq_hi, irq_lo}, 16'd0);

    // R7/R8 high group
    sel = 4'd12; write_ctrl(16'h00C4);
    pulse(4'b1000);
    chk("R7 irq high line", {14'd0, irq_hi, irq_lo}, 16'd2);
    poll = 1; poll_grp = 1; #1;
    chk("R8 high group resp", {8'd0, resp}, 16'h0010);
    tick(); poll = 0;

    // R5 edge in same cycle as read
    read_stat(); tick(2);
    timer_evt = 1; tick(2);
    rd_stat = 1; tick(); rd_stat = 0;
    m_f = 5'b00010;
    chk("R5 same-cycle edge kept", stat, exp_stat(m_f, m_c, btn, strap));
    timer_evt = 0; tick(4);

    // R9 soft reset via bit 5 and via bus init
    write_ctrl(16'h00C7); pulse(4'b1101);
    write_ctrl(16'h0020); tick();
    chk("R9 soft reset status", stat, exp_stat('0, '0, btn, strap));
    chk("R9 soft reset irq", {14'd0, irq_hi, irq_lo}, 16'd0);
    write_ctrl(16'h00C7); pulse(4'b0011);
    bus_init = 1; tick(); bus_init = 0; m_c = '0; m_f = '0;
    chk("R9 bus init status", stat, exp_stat('0, '0, btn, strap));

    // random
    for (int i = 0; i < 40; i++) begin
      logic [15:0] c;
      logic [3:0]  m;
      c = 16'($urandom()); c[5] = 1'b0;
      strap = 2'($urandom()); btn = 2'($urandom()); sel = 4'($urandom());
      m = 4'($urandom());
      read_stat();
      write_ctrl(c);
      pulse(m);
      chk("R3/R7 random status", stat, exp_stat(m_f, m_c, btn, strap));
      chk("R7 random irq", {14'd0, irq_hi, irq_lo}, {14'd0, exp_irq(m_f, m_c, sel)});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule